// File: doc/BRIEF.md
# Broadcast Request Controller with Two-Verdict Join

This block is the source node of a shared message bus. It takes a request from its input. It broadcasts the payload to every attached sink with a single write strobe. The sinks wake on that strobe rather than on any schedule. Three sinks listen to the broadcast: an authorisation worker, a response worker and a passive logger. Only the first two answer, and the controller never waits on the logger.

After the broadcast the controller stops sourcing and waits for a verdict from each of the two workers. Each verdict is an accept or a reject. Both workers must accept before the block emits a one-cycle reply strobe carrying the original payload. A single reject ends the transaction at once with a one-cycle drop strobe. A wait that outlasts a programmable limit also ends with a drop strobe. In every case the controller is idle again on the following cycle.

Each broadcast carries a 4-bit transaction tag that the workers echo back. Verdicts with the wrong tag, verdicts that arrive outside the waiting phase, and repeat verdicts from a worker that has already answered are all ignored. While a transaction is in flight the input is held off by a low ready signal, so no request is lost.

Top module: `rj_join_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_wr`, `reply_valid` and `drop_valid` are 0, and the first broadcast carries tag 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle only, `bus_wr` is 1, with `bus_data` equal to the accepted payload and `bus_tid` equal to the tag. The tag rises by one for each accepted request and wraps from 15 to 0.
- R3: From the broadcast cycle through the strobe cycle, `req_ready` is 0. A request held on the input during that time is accepted once the controller is idle again.
- R4: The two accept verdicts may arrive in either order or in the same cycle. When the second one is sampled, `reply_valid` is 1 for exactly the next cycle, with `reply_data` equal to the broadcast payload.
- R5: A reject verdict from either worker (`*_ack` = 0) makes `drop_valid` 1 in the cycle after it is sampled. The controller does not wait for the other worker.
- R6: A verdict is ignored if its tag differs from the current tag, or if it arrives while the controller is not in the waiting phase.
- R7: Within one transaction, only the first valid verdict from each worker counts. Later verdicts from that worker are ignored, even if they carry the opposite answer.
- R8: Let the limit be `timeout_cycles`, where 0 selects the default of 1024. If no decision is reached within that many waiting cycles, `drop_valid` is 1 in the next cycle. A verdict that decides the outcome in the last waiting cycle wins over the expiry.
- R9: In the cycle after a reply or drop strobe, `req_ready` is 1 again.
- R10: `reply_valid` and `drop_valid` are never both 1. Each broadcast produces exactly one strobe, which lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request present |
| req_data | input | DATA_W | Request payload |
| req_ready | output | 1 | Controller idle and able to accept |
| timeout_cycles | input | TMO_W | Wait limit in cycles, 0 selects the default |
| bus_wr | output | 1 | Broadcast write strobe to all sinks |
| bus_data | output | DATA_W | Broadcast payload |
| bus_tid | output | 4 | Transaction tag of the broadcast |
| auth_valid | input | 1 | Authorisation verdict present |
| auth_ack | input | 1 | 1 accept, 0 reject |
| auth_tid | input | 4 | Tag echoed by the authorisation worker |
| resp_valid | input | 1 | Response verdict present |
| resp_ack | input | 1 | 1 accept, 0 reject |
| resp_tid | input | 4 | Tag echoed by the response worker |
| reply_valid | output | 1 | One-cycle reply to the requester |
| reply_data | output | DATA_W | Payload returned with the reply |
| drop_valid | output | 1 | One-cycle drop of the connection |

## Verification
Three results have fixed delays. The broadcast strobe is due in the cycle after the accepting edge. A reply or drop strobe is due in the cycle after the edge at which the deciding verdict or the expiry is sampled. Ready returns in the cycle after the strobe. For each transaction, the bench works out from the two verdict delays, the two verdict values and the limit which waiting cycle decides the outcome and which strobe follows. It drives verdicts just after the falling edge and samples every output at the falling edge, checking the strobes in every cycle from the broadcast up to one cycle past the expected strobe. Between those points it adds stale-tag verdicts, repeat verdicts with the opposite answer, verdicts sent in the strobe cycle, and requests held back against a low ready. All of these must leave the predicted timing unchanged.

// File: rtl/rj_pkg.sv
package rj_pkg;

    localparam int TID_W     = 4;
    localparam int N_WORKERS = 2;
    localparam int WK_AUTH   = 0;
    localparam int WK_RESP   = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_REPLY = 2'd2,
        ST_DROP  = 2'd3
    } rj_state_e;

    typedef struct packed {
        logic             valid;
        logic             ack;
        logic [TID_W-1:0] tid;
    } rj_verdict_t;

    typedef struct packed {
        logic got;
        logic ack;
    } rj_slot_t;

    function automatic logic [TID_W-1:0] tid_step(input logic [TID_W-1:0] t);
        return t + 1'b1;
    endfunction

    // Reject beats a completed accept; real verdicts beat expiry.
    function automatic rj_state_e wait_next(input logic nack_any,
                                            input logic all_ack,
                                            input logic expire);
        if (nack_any)     return ST_DROP;
        else if (all_ack) return ST_REPLY;
        else if (expire)  return ST_DROP;
        else              return ST_WAIT;
    endfunction

endpackage

// File: rtl/rj_verdict_slot.sv
module rj_verdict_slot
    import rj_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic [TID_W-1:0] cur_tid,
    input  rj_verdict_t      vin,
    output rj_slot_t         eff
);

    rj_slot_t held_q;
    logic     hit;

    // A verdict counts only while waiting, with the live tag, and only once.
    assign hit = enable && vin.valid && (vin.tid == cur_tid) && !held_q.got;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            held_q <= '0;
        end else if (hit) begin
            held_q.got <= 1'b1;
            held_q.ack <= vin.ack;
        end
    end

    always_comb begin
        eff.got = held_q.got || hit;
        eff.ack = held_q.got ? held_q.ack : (hit && vin.ack);
    end

    AST_SLOT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (held_q.got && !clear) |=> (held_q.got && held_q.ack == $past(held_q.ack))); // R7

endmodule

// File: rtl/rj_wait_timer.sv
module rj_wait_timer #(
    parameter int TMO_W       = 16,
    parameter int TMO_DEFAULT = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);

    localparam logic [TMO_W:0] DEF_LIM = (TMO_W+1)'(TMO_DEFAULT);
    localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   lim_eff;
    logic [TMO_W:0]   cnt_plus;

    assign lim_eff  = (limit == '0) ? DEF_LIM : {1'b0, limit};
    assign cnt_plus = {1'b0, cnt_q} + 1'b1;
    assign expire   = run && (cnt_plus >= lim_eff);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (run && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TMR_FRESH: assert property (@(posedge clk) disable iff (rst)
        start |=> !expire || (limit == 1)); // R8

endmodule

// File: rtl/rj_join_ctrl.sv
module rj_join_ctrl
    import rj_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int TMO_W       = 16,
    parameter int TMO_DEFAULT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    input  logic [TMO_W-1:0]  timeout_cycles,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_data,
    output logic [TID_W-1:0]  bus_tid,
    input  logic              auth_valid,
    input  logic              auth_ack,
    input  logic [TID_W-1:0]  auth_tid,
    input  logic              resp_valid,
    input  logic              resp_ack,
    input  logic [TID_W-1:0]  resp_tid,
    output logic              reply_valid,
    output logic [DATA_W-1:0] reply_data,
    output logic              drop_valid
);

    rj_state_e         state_q, state_d;
    logic [DATA_W-1:0] payload_q;
    logic [TID_W-1:0]  cur_tid_q;
    logic [TID_W-1:0]  issue_tid_q;
    logic              wr_q;

    logic              accept;
    logic              in_wait;
    logic              expire;
    logic              nack_any;
    logic              all_ack;

    rj_verdict_t       vin [N_WORKERS];
    rj_slot_t          eff [N_WORKERS];

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign in_wait = (state_q == ST_WAIT);

    assign vin[WK_AUTH] = '{valid: auth_valid, ack: auth_ack, tid: auth_tid};
    assign vin[WK_RESP] = '{valid: resp_valid, ack: resp_ack, tid: resp_tid};

    for (genvar g = 0; g < N_WORKERS; g++) begin : g_slot
        rj_verdict_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .clear   (accept),
            .enable  (in_wait),
            .cur_tid (cur_tid_q),
            .vin     (vin[g]),
            .eff     (eff[g])
        );
    end

    always_comb begin
        nack_any = 1'b0;
        all_ack  = 1'b1;
        for (int i = 0; i < N_WORKERS; i++) begin
            nack_any = nack_any || (eff[i].got && !eff[i].ack);
            all_ack  = all_ack && eff[i].got && eff[i].ack;
        end
    end

    rj_wait_timer #(
        .TMO_W       (TMO_W),
        .TMO_DEFAULT (TMO_DEFAULT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .run    (in_wait),
        .limit  (timeout_cycles),
        .expire (expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_WAIT;
            ST_WAIT:  state_d = wait_next(nack_any, all_ack, expire);
            ST_REPLY: state_d = ST_IDLE;
            ST_DROP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            payload_q   <= '0;
            cur_tid_q   <= '0;
            issue_tid_q <= '0;
            wr_q        <= 1'b0;
        end else begin
            state_q <= state_d;
            wr_q    <= accept;
            if (accept) begin
                payload_q   <= req_data;
                cur_tid_q   <= issue_tid_q;
                issue_tid_q <= tid_step(issue_tid_q);
            end
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign bus_wr      = wr_q;
    assign bus_data    = payload_q;
    assign bus_tid     = cur_tid_q;
    assign reply_valid = (state_q == ST_REPLY);
    assign reply_data  = payload_q;
    assign drop_valid  = (state_q == ST_DROP);

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !bus_wr); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> !req_ready); // R3

    AST_REPLY_AFTER_ACKS: assert property (@(posedge clk) disable iff (rst)
        $rose(reply_valid) |-> $past(eff[WK_AUTH].ack && eff[WK_RESP].ack)); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(reply_valid && drop_valid)); // R10

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (reply_valid || drop_valid) |=> !(reply_valid || drop_valid)); // R10

    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (reply_valid || drop_valid) |=> req_ready); // R9

endmodule

// File: tb/test_rj_join_ctrl.sv
module test_rj_join_ctrl;

    localparam int DW    = 32;
    localparam int TW    = 16;
    localparam int NEVER = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready;
    logic [TW-1:0] timeout_cycles = 16'd20;
    logic          bus_wr;
    logic [DW-1:0] bus_data;
    logic [3:0]    bus_tid;
    logic          auth_valid = 1'b0, auth_ack = 1'b0;
    logic [3:0]    auth_tid = '0;
    logic          resp_valid = 1'b0, resp_ack = 1'b0;
    logic [3:0]    resp_tid = '0;
    logic          reply_valid;
    logic [DW-1:0] reply_data;
    logic          drop_valid;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] exp_tid = 4'd0;

    always #10 clk = ~clk;

    rj_join_ctrl #(.DATA_W(DW), .TMO_W(TW), .TMO_DEFAULT(1024)) i_rj_join_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_data(req_data), .req_ready(req_ready),
        .timeout_cycles(timeout_cycles),
        .bus_wr(bus_wr), .bus_data(bus_data), .bus_tid(bus_tid),
        .auth_valid(auth_valid), .auth_ack(auth_ack), .auth_tid(auth_tid),
        .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_tid(resp_tid),
        .reply_valid(reply_valid), .reply_data(reply_data), .drop_valid(drop_valid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Returns the deciding waiting-cycle index; sets is_reply.
    function automatic int predict(input int lim, input int da, input bit aa,
                                   input int dr, input bit ar, output bit is_reply);
        int lim_eff, tn, tb, dec;
        lim_eff = (lim == 0) ? 1024 : lim;
        tn = imin(aa ? NEVER : da, ar ? NEVER : dr);
        tb = (aa && ar && da != NEVER && dr != NEVER) ? ((da > dr) ? da : dr) : NEVER;
        dec = imin(tn, tb);
        if (dec <= lim_eff - 1) begin
            is_reply = (tb < tn);
            return dec;
        end
        is_reply = 1'b0;
        return lim_eff - 1;
    endfunction

    task automatic drive_worker(input int k, input int d, input bit a, input int t_end,
                                input bit noise, output logic v, output logic ak,
                                output logic [3:0] tg);
        v = 1'b0; ak = 1'b0; tg = 4'd0;
        if (k == t_end + 1) begin
            // strobe cycle: verdict for the upcoming tag must be ignored (R6)
            v = 1'b1; ak = 1'b1; tg = exp_tid;
        end else if (k == d) begin
            v = 1'b1; ak = a; tg = exp_tid - 4'd1;
        end else if (noise && d != NEVER && k > d && ($urandom % 2) == 1) begin
            v = 1'b1; ak = ~a; tg = exp_tid - 4'd1;         // repeat, R7
        end else if (noise && ($urandom % 3) == 0) begin
            v = 1'b1; ak = 1'($urandom); tg = (exp_tid - 4'd1) ^ 4'h5; // stale, R6
        end
    endtask

    task automatic run_txn(input logic [DW-1:0] pay, input int lim,
                           input int da, input bit aa, input int dr, input bit ar,
                           input bit noise, input bit preload, input logic [DW-1:0] next_pay);
        bit found, is_reply;
        int t;
        timeout_cycles = TW'(lim);
        req_valid = 1'b1;
        req_data  = pay;
        found = 1'b0;
        for (int i = 0; i < 6 && !found; i++) begin
            @(posedge clk); @(negedge clk);
            if (bus_wr) found = 1'b1;
        end
        chk(found, "R2 broadcast strobe", found, 1);
        chk(bus_data == pay, "R2 bus_data", bus_data, pay);
        chk(bus_tid == exp_tid, "R2 bus_tid", bus_tid, exp_tid);
        exp_tid = exp_tid + 4'd1;
        req_valid = 1'b0;
        t = predict(lim, da, aa, dr, ar, is_reply);
        for (int k = 0; k <= t + 1; k++) begin
            chk(reply_valid == (k == t + 1 && is_reply), "R4 reply_valid timing", reply_valid, (k == t + 1 && is_reply));
            chk(drop_valid == (k == t + 1 && !is_reply), "R5 R8 drop_valid timing", drop_valid, (k == t + 1 && !is_reply));
            chk(req_ready == 1'b0, "R3 ready low while busy", req_ready, 0);
            if (k == 0) chk(bus_wr == 1'b1, "R2 strobe in first cycle", bus_wr, 1);
            else        chk(bus_wr == 1'b0, "R2 strobe one cycle", bus_wr, 0);
            if (k == t + 1 && is_reply)
                chk(reply_data == pay, "R4 reply_data", reply_data, pay);
            drive_worker(k, da, aa, t, noise, auth_valid, auth_ack, auth_tid);
            drive_worker(k, dr, ar, t, noise, resp_valid, resp_ack, resp_tid);
            if (preload && k >= 1) begin
                req_valid = 1'b1;
                req_data  = next_pay;
            end
            @(posedge clk); @(negedge clk);
        end
        auth_valid = 1'b0;
        resp_valid = 1'b0;
        chk(req_ready == 1'b1, "R9 ready after strobe", req_ready, 1);
        chk(!reply_valid && !drop_valid, "R10 single strobe", reply_valid | drop_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(!bus_wr && !reply_valid && !drop_valid, "R1 outputs quiet", bus_wr | reply_valid | drop_valid, 0);

        // R1 first tag is 0 (checked in run_txn); R4 same-cycle accepts
        run_txn(32'hA001, 20, 2, 1, 2, 1, 0, 0, '0);
        // R4 auth first, then resp; then reversed
        run_txn(32'hA002, 20, 1, 1, 5, 1, 0, 0, '0);
        run_txn(32'hA003, 20, 6, 1, 0, 1, 0, 0, '0);
        // R5 early reject, other never answers
        run_txn(32'hA004, 20, NEVER, 1, 0, 0, 0, 0, '0);
        // R5 reject after the other accepted
        run_txn(32'hA005, 20, 3, 0, 1, 1, 0, 0, '0);
        // R8 limit 1 and last-cycle verdict priority and plain expiry
        run_txn(32'hA006, 1, NEVER, 1, NEVER, 1, 0, 0, '0);
        run_txn(32'hA007, 5, 4, 1, 4, 1, 0, 0, '0);
        run_txn(32'hA008, 5, 2, 1, NEVER, 1, 0, 0, '0);
        // R8 limit 0 selects 1024
        run_txn(32'hA009, 0, NEVER, 1, NEVER, 1, 0, 0, '0);
        // R3 request held during a transaction is accepted afterwards
        run_txn(32'hA00A, 20, 2, 1, 3, 1, 1, 1, 32'hB00B);
        run_txn(32'hB00B, 20, 1, 1, 1, 1, 1, 0, '0);

        // R6 R7 random mix with stale and repeat verdicts; tags wrap (R2)
        for (int n = 0; n < 60; n++) begin
            int lim, da, dr;
            bit aa, ar, pre;
            logic [DW-1:0] p0, p1;
            lim = 1 + ($urandom % 12);
            da  = (($urandom % 8) == 0) ? NEVER : int'($urandom % 11);
            dr  = (($urandom % 8) == 0) ? NEVER : int'($urandom % 11);
            aa  = (($urandom % 4) != 0);
            ar  = (($urandom % 4) != 0);
            pre = (($urandom % 3) == 0);
            p0  = $urandom;
            p1  = $urandom;
            run_txn(p0, lim, da, aa, dr, ar, 1, pre, p1);
            if (pre) run_txn(p1, 12, 1, 1, 2, 1, 1, 0, '0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule